// File: doc/BRIEF.md
# Printer Port Register Block

This block is the host-side register window of a byte-wide parallel printer port. A simple synchronous CPU bus reaches three registers through the low three address bits: a data register at offset 0, a status register at offset 1 and a control register at offset 2. The block has no real cable timing. It models the printer handshake itself. A rising strobe written through the control register sends the latched output byte to a character sink as a one-cycle valid pulse and clears busy. Later status reads step the acknowledge and busy flags as a printer would.

A level interrupt request follows an internal pending flag. The flag is set by a strobe-low control write while interrupts are enabled and cleared by any status read. An 8-bit input latch samples the external data lines every cycle. Software sees that latch through the data register when the direction bit is set.

Top module: `prtport_regs`

## Requirements
- R1: After reset, the data register reads 0xFF, status reads 0xD9 (busy bit 7, ack bit 6, online bit 4, error bit 3, timeout bit 0), control reads 0xCC, `irq` is low and `sink_valid` is low.
- R2: Only the low three address bits are decoded. Reads of offsets 3 to 7 return 0xFF. Writes to offsets 1 and 3 to 7 change no register.
- R3: A control write stores the written byte ORed with 0xC0. Field positions: strobe bit 0, auto-linefeed bit 1, init bit 2, select bit 3, interrupt-enable bit 4, direction bit 5.
- R4: A control write with init low sets status to 0xD8.
- R5: A control write with init, select and strobe all high clears status bit 7. If the stored strobe bit was low before the write, the current output byte appears on `sink_byte` with `sink_valid` high for exactly one cycle. Otherwise nothing is emitted.
- R6: A control write with init and select high and strobe low sets the pending flag, but only if the control value stored before the write had interrupt-enable set.
- R7: A status read returns the status value held before the read and clears the pending flag.
- R8: On a status read with status bit 7 clear and stored strobe clear, ack (bit 6) is cleared if it was set. Otherwise ack and busy are both set.
- R9: A data read returns the input latch (the `line_in` value sampled one cycle earlier) when control bit 5 is set, and the last written data byte otherwise.
- R10: `acc_rdata` and `irq` are registered. Both take their new values on the clock edge that accepts the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Bus access valid this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte address; low three bits decoded |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid the cycle after a read |
| line_in | input | 8 | External data lines into the input latch |
| sink_valid | output | 1 | One-cycle pulse for an emitted byte |
| sink_byte | output | 8 | Emitted byte |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with `ADDR_W` at its default of 8. This lets random addresses set upper bits and checks that offsets such as 0x81 alias onto the status register. A behavioural model tracks every register and is compared on each clock. It covers repeated strobe-high writes, the interrupt-enable-before-write rule, the ack/busy toggle sequence on back-to-back status reads, and input-latch reads with the direction bit set.

// File: rtl/prtport_pkg.sv
package prtport_pkg;

    localparam int DEC_W = 3;

    localparam logic [DEC_W-1:0] OFF_DATA = 3'd0;
    localparam logic [DEC_W-1:0] OFF_STAT = 3'd1;
    localparam logic [DEC_W-1:0] OFF_CTRL = 3'd2;

    localparam int ST_BUSY  = 7;
    localparam int ST_ACK   = 6;
    localparam int ST_ONLN  = 4;
    localparam int ST_ERR   = 3;
    localparam int ST_TMO   = 0;

    localparam int CT_STRB  = 0;
    localparam int CT_INIT  = 2;
    localparam int CT_SEL   = 3;
    localparam int CT_IEN   = 4;
    localparam int CT_DIR   = 5;

    localparam logic [7:0] CTRL_FORCED = 8'hC0;
    localparam logic [7:0] STAT_RST    = 8'hD9;
    localparam logic [7:0] STAT_INITLO = 8'hD8;
    localparam logic [7:0] CTRL_RST    = 8'hCC;

    typedef struct packed {
        logic [7:0] dout;
        logic [7:0] din;
        logic [7:0] stat;
        logic [7:0] ctrl;
        logic       pend;
        logic       sv;
        logic [7:0] sb;
        logic [7:0] rd;
    } regs_t;

endpackage

// File: rtl/prtport_ctl_write.sv
module prtport_ctl_write
    import prtport_pkg::*;
(
    input  logic [7:0] ctrl_cur,
    input  logic [7:0] stat_cur,
    input  logic [7:0] wbyte,
    output logic [7:0] ctrl_new,
    output logic [7:0] stat_new,
    output logic       set_pend,
    output logic       emit
);
    always_comb begin
        ctrl_new = wbyte | CTRL_FORCED;
        stat_new = stat_cur;
        set_pend = 1'b0;
        emit     = 1'b0;
        if (!ctrl_new[CT_INIT]) begin
            stat_new = STAT_INITLO;
        end else if (ctrl_new[CT_SEL]) begin
            if (ctrl_new[CT_STRB]) begin
                stat_new[ST_BUSY] = 1'b0;
                emit = !ctrl_cur[CT_STRB];
            end else begin
                set_pend = ctrl_cur[CT_IEN];
            end
        end
    end
endmodule

// File: rtl/prtport_rd_path.sv
module prtport_rd_path
    import prtport_pkg::*;
(
    input  logic [DEC_W-1:0] off,
    input  logic [7:0]       ctrl_cur,
    input  logic [7:0]       stat_cur,
    input  logic [7:0]       dout_cur,
    input  logic [7:0]       din_cur,
    output logic [7:0]       rbyte,
    output logic [7:0]       stat_after
);
    always_comb begin
        unique case (off)
            OFF_DATA: rbyte = ctrl_cur[CT_DIR] ? din_cur : dout_cur;
            OFF_STAT: rbyte = stat_cur;
            OFF_CTRL: rbyte = ctrl_cur;
            default:  rbyte = 8'hFF;
        endcase
    end

    always_comb begin
        stat_after = stat_cur;
        if (!stat_cur[ST_BUSY] && !ctrl_cur[CT_STRB]) begin
            if (stat_cur[ST_ACK]) begin
                stat_after[ST_ACK] = 1'b0;
            end else begin
                stat_after[ST_ACK]  = 1'b1;
                stat_after[ST_BUSY] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/prtport_regs.sv
module prtport_regs
    import prtport_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [7:0]        acc_wdata,
    output logic [7:0]        acc_rdata,
    input  logic [7:0]        line_in,
    output logic              sink_valid,
    output logic [7:0]        sink_byte,
    output logic              irq
);
    localparam int OFF_LSB = 0;

    regs_t r_q, r_d;

    logic [DEC_W-1:0] off;
    logic [7:0] cw_ctrl, cw_stat, rp_byte, rp_stat;
    logic       cw_pend, cw_emit;

    assign off = acc_addr[OFF_LSB +: DEC_W];

    prtport_ctl_write u_cw (
        .ctrl_cur (r_q.ctrl),
        .stat_cur (r_q.stat),
        .wbyte    (acc_wdata),
        .ctrl_new (cw_ctrl),
        .stat_new (cw_stat),
        .set_pend (cw_pend),
        .emit     (cw_emit)
    );

    prtport_rd_path u_rp (
        .off        (off),
        .ctrl_cur   (r_q.ctrl),
        .stat_cur   (r_q.stat),
        .dout_cur   (r_q.dout),
        .din_cur    (r_q.din),
        .rbyte      (rp_byte),
        .stat_after (rp_stat)
    );

    always_comb begin
        r_d     = r_q;
        r_d.din = line_in;
        r_d.sv  = 1'b0;
        if (acc_en && acc_wr) begin
            if (off == OFF_DATA) begin
                r_d.dout = acc_wdata;
            end else if (off == OFF_CTRL) begin
                r_d.ctrl = cw_ctrl;
                r_d.stat = cw_stat;
                if (cw_pend) r_d.pend = 1'b1;
                if (cw_emit) begin
                    r_d.sv = 1'b1;
                    r_d.sb = r_q.dout;
                end
            end
        end else if (acc_en) begin
            r_d.rd = rp_byte;
            if (off == OFF_STAT) begin
                r_d.pend = 1'b0;
                r_d.stat = rp_stat;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.dout <= 8'hFF;
            r_q.din  <= 8'hFF;
            r_q.stat <= STAT_RST;
            r_q.ctrl <= CTRL_RST;
            r_q.pend <= 1'b0;
            r_q.sv   <= 1'b0;
            r_q.sb   <= 8'h00;
            r_q.rd   <= 8'hFF;
        end else begin
            r_q <= r_d;
        end
    end

    assign acc_rdata  = r_q.rd;
    assign sink_valid = r_q.sv;
    assign sink_byte  = r_q.sb;
    assign irq        = r_q.pend;

    // R5: never two emitted bytes back to back
    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sink_valid |=> !sink_valid);

    // R5: strobe rising write emits the byte that was latched
    p_emit_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && off == OFF_CTRL && acc_wdata[CT_INIT] &&
         acc_wdata[CT_SEL] && acc_wdata[CT_STRB] && !r_q.ctrl[CT_STRB])
        |=> (sink_valid && sink_byte == $past(r_q.dout)));

    // R4: init low forces the fixed status pattern
    p_init_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && off == OFF_CTRL && !acc_wdata[CT_INIT])
        |=> (r_q.stat == STAT_INITLO));

    // R7: a status read drops the interrupt request
    p_stat_read_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_wr && off == OFF_STAT) |=> !irq);

    // R6: interrupt only rises when enable was already stored
    p_irq_needs_ien_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(r_q.ctrl[CT_IEN]));

    // R2: unmapped offsets read as all ones
    p_unmapped_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_wr && off > OFF_CTRL) |=> (acc_rdata == 8'hFF));

    // R3: forced control bits stay set
    p_ctrl_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && off == OFF_CTRL) |=> (r_q.ctrl[7:6] == 2'b11));
endmodule

// File: tb/sim_prtport_regs.sv
module sim_prtport_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_en = 1'b0;
    logic       acc_wr = 1'b0;
    logic [7:0] acc_addr = 8'h00;
    logic [7:0] acc_wdata = 8'h00;
    logic [7:0] line_in = 8'h00;
    logic [7:0] acc_rdata;
    logic       sink_valid;
    logic [7:0] sink_byte;
    logic       irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    prtport_regs #(.ADDR_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .line_in(line_in), .sink_valid(sink_valid), .sink_byte(sink_byte),
        .irq(irq)
    );

    // behavioural reference model
    int m_dout, m_din, m_stat, m_ctrl, m_pend, m_sv, m_sb, m_rd, m_rdv;
    string m_tag;

    always @(posedge clk) begin
        int o, v;
        if (!rst_n) begin
            m_dout = 255; m_din = 255; m_stat = 'hD9; m_ctrl = 'hCC;
            m_pend = 0; m_sv = 0; m_sb = 0; m_rd = 255; m_rdv = 0;
            m_tag = "R1";
        end else begin
            m_sv = 0;
            m_rdv = 0;
            o = acc_addr % 8;
            if (acc_en && acc_wr) begin
                if (o == 0) m_dout = acc_wdata;
                else if (o == 2) begin
                    v = acc_wdata | 'hC0;
                    if ((v & 4) == 0) m_stat = 'hD8;
                    else if (v & 8) begin
                        if (v & 1) begin
                            m_stat = m_stat & 'h7F;
                            if ((m_ctrl & 1) == 0) begin m_sv = 1; m_sb = m_dout; end
                        end else if (m_ctrl & 16) m_pend = 1;
                    end
                    m_ctrl = v;
                end
            end else if (acc_en) begin
                m_rdv = 1;
                case (o)
                    0: begin m_rd = (m_ctrl & 32) ? m_din : m_dout; m_tag = "R9"; end
                    1: begin
                        m_rd = m_stat; m_tag = "R7"; m_pend = 0;
                        if ((m_stat & 128) == 0 && (m_ctrl & 1) == 0) begin
                            if (m_stat & 64) m_stat = m_stat & 'hBF;
                            else m_stat = m_stat | 'hC0;
                        end
                    end
                    2: begin m_rd = m_ctrl; m_tag = "R3"; end
                    default: begin m_rd = 255; m_tag = "R2"; end
                endcase
            end
            m_din = line_in;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk("R6/R10 irq", irq, m_pend);
            chk("R5 sink_valid", sink_valid, m_sv);
            if (m_sv) chk("R5 sink_byte", sink_byte, m_sb);
            if (m_rdv) chk({m_tag, " rdata"}, acc_rdata, m_rd);
        end
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic acc(input logic w, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = w; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_en = 1'b0;
    endtask

    task automatic rd_expect(input logic [7:0] a, input logic [7:0] exp, input string req);
        acc(1'b0, a, 8'h00);
        chk(req, acc_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 irq", irq, 0);
        chk("R1 sink", sink_valid, 0);
        rd_expect(8'h00, 8'hFF, "R1 data");
        rd_expect(8'h02, 8'hCC, "R1 ctrl");
        rd_expect(8'h01, 8'hD9, "R1 status");
        // R3 forced bits
        acc(1'b1, 8'h02, 8'h0C);
        rd_expect(8'h02, 8'hCC, "R3 ctrl readback");
        acc(1'b1, 8'h00, 8'h5A);
        // R5 rising strobe emits once
        acc(1'b1, 8'h02, 8'h0D);
        acc(1'b1, 8'h02, 8'h0D);
        rd_expect(8'h01, 8'h59, "R5 busy cleared");
        // R8 toggle: strobe low then status reads
        acc(1'b1, 8'h02, 8'h0C);
        rd_expect(8'h01, 8'h59, "R8 first read");
        rd_expect(8'h01, 8'h19, "R8 ack cleared");
        rd_expect(8'h01, 8'hD9, "R8 ack and busy set");
        // R6 interrupt
        acc(1'b1, 8'h02, 8'h0D);
        acc(1'b1, 8'h02, 8'h0C);
        chk("R6 no irq without enable", irq, 0);
        acc(1'b1, 8'h02, 8'h1C);
        acc(1'b1, 8'h02, 8'h1C);
        chk("R6 irq set", irq, 1);
        rd_expect(8'h81, 8'h59, "R2 alias status");
        chk("R7 irq cleared", irq, 0);
        // R4 init low
        acc(1'b1, 8'h02, 8'h08);
        rd_expect(8'h01, 8'hD8, "R4 status forced");
        // R9 input latch
        line_in = 8'h3C;
        acc(1'b1, 8'h02, 8'h2C);
        rd_expect(8'h00, 8'h3C, "R9 input latch");
        acc(1'b1, 8'h02, 8'h0C);
        rd_expect(8'h00, 8'h5A, "R9 output latch");
        // R2 unmapped writes and reads
        acc(1'b1, 8'h03, 8'h00);
        acc(1'b1, 8'h0F, 8'h00);
        acc(1'b1, 8'h01, 8'h00);
        rd_expect(8'h00, 8'h5A, "R2 data untouched");
        rd_expect(8'h02, 8'hCC, "R2 ctrl untouched");
        for (int k = 3; k < 8; k++) rd_expect(8'(k), 8'hFF, "R2 unmapped read");
        // random traffic against model
        for (int i = 0; i < 2000; i++) begin
            line_in = 8'($urandom);
            acc(1'($urandom), 8'($urandom) & 8'h83 | ($urandom % 2 ? 8'h00 : 8'h04),
                8'($urandom) | 8'h0C & 8'($urandom | 32'h0C));
        end
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule